// File: doc/BRIEF.md
# Password-Guarded Clock Control Register Bank

This block is the software-visible register bank of a clock manager. It holds the control words for a set of PLLs, for the output channels hanging off each PLL, and for a row of clock selectors, each of which has a control word and a divider word. A write only lands if the top byte of the written data carries a fixed key. Before the value is stored, that key byte is removed, so stored words always read back with a zero top byte. Writes with the wrong key leave the bank untouched.

Whenever a write is accepted, the bank raises one-cycle update strobes. These tell the downstream PLL, channel and selector logic which of their entries must be re-evaluated. A control word that a PLL shares with its channels wakes the PLL and all of that PLL's channels at once.

One word is a read-only lock summary. It is not stored. It is formed live from each PLL's power-down bit and analog-reset bit.

Top module: `clkreg_bank`

## Requirements
- R1: After reset every word reads zero, except the PLL analog words, which read 0x0001_0000 (power-down bit 16 set). The lock word therefore reads zero.
- R2: A write is accepted only when data bits 31:24 equal 0x5A. Any other key leaves every register unchanged and raises no strobe.
- R3: An accepted write stores data bits 23:0. Reads of stored words return bits 31:24 as zero.
- R4: Only word-aligned accesses are valid (address bits 1:0 zero). A misaligned write is ignored and raises no strobe, and a misaligned read returns zero.
- R5: Word map, with byte address equal to 4 times the word number:
  - PLL p control word at word p, with its analog-reset hold bit at bit 8.
  - PLL p analog word at word 8+p, with its power-down bit at bit 16.
  - Channel c at word 16+c. Channel c belongs to PLL c/CH_PER_PLL.
  - Selector m control at word 32+2m, and its divider one word later at 33+2m.
  - Lock summary at the last word (63).
- R6: Lock word bit p is 1 exactly when PLL p's control bit 8 is clear and its analog bit 16 is clear. Bits NUM_PLL and above read zero. The value reflects the registers as they stand, with no extra storage.
- R7: The lock word is read-only. Writes to it are ignored and raise no strobe.
- R8: Unimplemented words read zero. Writes to them are ignored and raise no strobe.
- R9: The strobes of an accepted write are high for exactly the one cycle after the clock edge that stores the write.
- R10: A write to PLL p's control word raises pll_upd[p] and chan_upd for every channel of PLL p. A write to PLL p's analog word raises only pll_upd[p].
- R11: A write to channel c's word raises only chan_upd[c].
- R12: A write to either selector m word (control or divider) raises only mux_upd[m].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request this cycle |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data, key in bits 31:24 |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| pll_upd | output | NUM_PLL | Per-PLL re-evaluate strobe |
| chan_upd | output | NUM_PLL*CH_PER_PLL | Per-channel re-evaluate strobe |
| mux_upd | output | NUM_MUX | Per-selector re-evaluate strobe |

## Verification
Every writable word is written with the correct key and a distinct data pattern. The full word map is then read back. This shows that each word is decoded to its own storage and that the key byte is stripped.

The same words are then written with keys that differ from 0x5A in one bit at a time, and with a zero key. This separates a full key compare from a partial one.

Misaligned offsets, unimplemented words and the lock word are hit with correctly keyed writes, which tells address filtering apart from key filtering.

Finally, all four combinations of the power-down and analog-reset bits are swept per PLL against the lock word. The strobe vector of each write is compared with the one expected from the word class, including the fan-out from a PLL control word to its channels.

// File: rtl/clkreg_pkg.sv
package clkreg_pkg;

  localparam int          KEY_LSB    = 24;
  localparam logic [7:0]  KEY_VALUE  = 8'h5A;
  localparam int          ANARST_BIT = 8;
  localparam int          PWRDN_BIT  = 16;

  typedef enum logic [2:0] {
    K_NONE, K_PLLCM, K_PLLANA, K_CHAN, K_MUXCTL, K_MUXDIV, K_LOCK
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [7:0] idx;
  } slot_t;

  function automatic logic key_ok(input logic [31:0] d);
    return d[31:KEY_LSB] == KEY_VALUE;
  endfunction

  function automatic logic [23:0] strip_key(input logic [31:0] d);
    return d[KEY_LSB-1:0];
  endfunction

  function automatic logic locked(input logic [23:0] cm, input logic [23:0] ana);
    return !cm[ANARST_BIT] && !ana[PWRDN_BIT];
  endfunction

endpackage

// File: rtl/clkreg_decode.sv
module clkreg_decode
  import clkreg_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_PLL    = 5,
  parameter int CH_PER_PLL = 2,
  parameter int NUM_MUX    = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output slot_t             slot,
  output logic              aligned
);
  localparam int NUM_CH   = NUM_PLL * CH_PER_PLL;
  localparam int CM_BASE  = 0;
  localparam int ANA_BASE = 8;
  localparam int CH_BASE  = 16;
  localparam int MUX_BASE = 32;
  localparam int NWORDS   = 1 << (ADDR_W - 2);
  localparam int LOCK_W   = NWORDS - 1;

  int w;

  always_comb begin
    w            = int'(addr[ADDR_W-1:2]);
    aligned      = (addr[1:0] == 2'b00);
    slot.kind    = K_NONE;
    slot.idx     = 8'd0;
    if (w >= CM_BASE && w < CM_BASE + NUM_PLL) begin
      slot.kind = K_PLLCM;
      slot.idx  = 8'(w - CM_BASE);
    end else if (w >= ANA_BASE && w < ANA_BASE + NUM_PLL) begin
      slot.kind = K_PLLANA;
      slot.idx  = 8'(w - ANA_BASE);
    end else if (w >= CH_BASE && w < CH_BASE + NUM_CH) begin
      slot.kind = K_CHAN;
      slot.idx  = 8'(w - CH_BASE);
    end else if (w >= MUX_BASE && w < MUX_BASE + 2 * NUM_MUX) begin
      slot.kind = ((w - MUX_BASE) % 2 == 0) ? K_MUXCTL : K_MUXDIV;
      slot.idx  = 8'((w - MUX_BASE) / 2);
    end else if (w == LOCK_W) begin
      slot.kind = K_LOCK;
    end
  end

endmodule

// File: rtl/clkreg_wfilter.sv
module clkreg_wfilter
  import clkreg_pkg::*;
(
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        aligned,
  input  slot_t       slot,
  output logic        accept,
  output logic [23:0] value
);
  logic writable;

  always_comb begin
    writable = (slot.kind != K_NONE) && (slot.kind != K_LOCK);
    accept   = wr_en && aligned && writable && key_ok(wr_data);
    value    = strip_key(wr_data);
  end

endmodule

// File: rtl/clkreg_lock.sv
module clkreg_lock #(
  parameter int NUM_PLL = 5
) (
  input  logic [NUM_PLL-1:0] anarst,
  input  logic [NUM_PLL-1:0] pwrdn,
  output logic [NUM_PLL-1:0] lock
);
  for (genvar i = 0; i < NUM_PLL; i++) begin : g_lk
    assign lock[i] = ~anarst[i] & ~pwrdn[i];
  end
endmodule

// File: rtl/clkreg_bank.sv
module clkreg_bank
  import clkreg_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          NUM_PLL     = 5,
  parameter int          CH_PER_PLL  = 2,
  parameter int          NUM_MUX     = 4,
  parameter logic [23:0] ANA_RST_VAL = 24'h01_0000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [31:0]                   wr_data,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [31:0]                   rd_data,
  output logic [NUM_PLL-1:0]            pll_upd,
  output logic [NUM_PLL*CH_PER_PLL-1:0] chan_upd,
  output logic [NUM_MUX-1:0]            mux_upd
);
  localparam int NUM_CH = NUM_PLL * CH_PER_PLL;

  slot_t       wslot, rslot;
  logic        waligned, raligned;
  logic        w_accept;
  logic [23:0] w_value;

  logic [23:0] cm_q   [NUM_PLL];
  logic [23:0] ana_q  [NUM_PLL];
  logic [23:0] ch_q   [NUM_CH];
  logic [23:0] mctl_q [NUM_MUX];
  logic [23:0] mdiv_q [NUM_MUX];

  logic [NUM_PLL-1:0] anarst_v, pwrdn_v, lock_w;
  logic [NUM_PLL-1:0] pll_nxt;
  logic [NUM_CH-1:0]  chan_nxt;
  logic [NUM_MUX-1:0] mux_nxt;

  clkreg_decode #(.ADDR_W(ADDR_W), .NUM_PLL(NUM_PLL), .CH_PER_PLL(CH_PER_PLL),
                  .NUM_MUX(NUM_MUX)) u_wdec (
    .addr(wr_addr), .slot(wslot), .aligned(waligned));

  clkreg_decode #(.ADDR_W(ADDR_W), .NUM_PLL(NUM_PLL), .CH_PER_PLL(CH_PER_PLL),
                  .NUM_MUX(NUM_MUX)) u_rdec (
    .addr(rd_addr), .slot(rslot), .aligned(raligned));

  clkreg_wfilter u_filt (
    .wr_en(wr_en), .wr_data(wr_data), .aligned(waligned), .slot(wslot),
    .accept(w_accept), .value(w_value));

  // Storage, one generate loop per word class
  for (genvar i = 0; i < NUM_PLL; i++) begin : g_pll
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cm_q[i]  <= '0;
        ana_q[i] <= ANA_RST_VAL;
      end else if (w_accept && wslot.idx == 8'(i)) begin
        if (wslot.kind == K_PLLCM)  cm_q[i]  <= w_value;
        if (wslot.kind == K_PLLANA) ana_q[i] <= w_value;
      end
    end
    assign anarst_v[i] = cm_q[i][ANARST_BIT];
    assign pwrdn_v[i]  = ana_q[i][PWRDN_BIT];
    assign pll_nxt[i]  = w_accept && wslot.idx == 8'(i) &&
                         (wslot.kind == K_PLLCM || wslot.kind == K_PLLANA);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)
        ch_q[c] <= '0;
      else if (w_accept && wslot.kind == K_CHAN && wslot.idx == 8'(c))
        ch_q[c] <= w_value;
    end
    assign chan_nxt[c] = w_accept &&
      ((wslot.kind == K_CHAN  && wslot.idx == 8'(c)) ||
       (wslot.kind == K_PLLCM && wslot.idx == 8'(c / CH_PER_PLL)));
  end

  for (genvar m = 0; m < NUM_MUX; m++) begin : g_mux
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mctl_q[m] <= '0;
        mdiv_q[m] <= '0;
      end else if (w_accept && wslot.idx == 8'(m)) begin
        if (wslot.kind == K_MUXCTL) mctl_q[m] <= w_value;
        if (wslot.kind == K_MUXDIV) mdiv_q[m] <= w_value;
      end
    end
    assign mux_nxt[m] = w_accept && wslot.idx == 8'(m) &&
                        (wslot.kind == K_MUXCTL || wslot.kind == K_MUXDIV);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pll_upd  <= '0;
      chan_upd <= '0;
      mux_upd  <= '0;
    end else begin
      pll_upd  <= pll_nxt;
      chan_upd <= chan_nxt;
      mux_upd  <= mux_nxt;
    end
  end

  clkreg_lock #(.NUM_PLL(NUM_PLL)) u_lock (
    .anarst(anarst_v), .pwrdn(pwrdn_v), .lock(lock_w));

  // Read mux
  always_comb begin
    rd_data = '0;
    if (raligned) begin
      unique case (rslot.kind)
        K_LOCK: rd_data = {{(32-NUM_PLL){1'b0}}, lock_w};
        K_PLLCM:
          for (int i = 0; i < NUM_PLL; i++)
            if (rslot.idx == 8'(i)) rd_data = {8'h00, cm_q[i]};
        K_PLLANA:
          for (int i = 0; i < NUM_PLL; i++)
            if (rslot.idx == 8'(i)) rd_data = {8'h00, ana_q[i]};
        K_CHAN:
          for (int i = 0; i < NUM_CH; i++)
            if (rslot.idx == 8'(i)) rd_data = {8'h00, ch_q[i]};
        K_MUXCTL:
          for (int i = 0; i < NUM_MUX; i++)
            if (rslot.idx == 8'(i)) rd_data = {8'h00, mctl_q[i]};
        K_MUXDIV:
          for (int i = 0; i < NUM_MUX; i++)
            if (rslot.idx == 8'(i)) rd_data = {8'h00, mdiv_q[i]};
        default: rd_data = '0;
      endcase
    end
  end

  // R2
  bad_key_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[31:24] != KEY_VALUE) |=>
      (pll_upd == '0 && chan_upd == '0 && mux_upd == '0));

  // R4
  misaligned_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[1:0] != 2'b00) |=>
      (pll_upd == '0 && chan_upd == '0 && mux_upd == '0));

  // R3
  top_byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:24] == 8'h00);

  // R10
  cm_fanout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_accept && wslot.kind == K_PLLCM) |=>
      ($countones(chan_upd) == CH_PER_PLL && $countones(pll_upd) == 1));

  // R12
  mux_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mux_upd));

  // R10
  pll_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pll_upd));

  // R6
  for (genvar i = 0; i < NUM_PLL; i++) begin : g_lock_chk
    lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cm_q[i][ANARST_BIT] || ana_q[i][PWRDN_BIT]) |-> !lock_w[i]);
  end

endmodule

// File: tb/clkreg_bank_bench.sv
module clkreg_bank_bench;
  localparam int NP = 5, CPP = 2, NC = 10, NM = 4, NW = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [NP-1:0] pll_upd;
  logic [NC-1:0] chan_upd;
  logic [NM-1:0] mux_upd;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [31:0] mdl [NW];

  always #4 clk = ~clk;

  clkreg_bank u_clkreg_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pll_upd(pll_upd), .chan_upd(chan_upd), .mux_upd(mux_upd));

  // 1 pll ctl, 2 pll analog, 3 channel, 4 mux ctl, 5 mux div, 6 lock, 0 none
  function automatic int cls(int w);
    if (w < NP) return 1;
    if (w >= 8 && w < 8 + NP) return 2;
    if (w >= 16 && w < 16 + NC) return 3;
    if (w >= 32 && w < 32 + 2 * NM) return ((w % 2) == 0) ? 4 : 5;
    if (w == NW - 1) return 6;
    return 0;
  endfunction

  function automatic logic [31:0] expect_word(int w);
    logic [31:0] l = '0;
    if (cls(w) == 6) begin
      for (int p = 0; p < NP; p++)
        l[p] = (mdl[p][8] == 1'b0) && (mdl[8 + p][16] == 1'b0);
      return l;
    end
    return mdl[w];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    rd_addr = a;
    #1;
    check(tag, rd_data, exp);
  endtask

  task automatic check_all(input string tag);
    for (int w = 0; w < NW; w++) rd_check(tag, 8'(4 * w), expect_word(w));
  endtask

  // Drive a write, check strobes in the following cycle and that they drop after it
  task automatic do_write(input string tag, input logic [7:0] a, input logic [31:0] d);
    logic [NP-1:0] ep = '0;
    logic [NC-1:0] ec = '0;
    logic [NM-1:0] em = '0;
    int w = int'(a) / 4;
    bit ok = (a[1:0] == 2'b00) && (d[31:24] == 8'h5A) && cls(w) != 0 && cls(w) != 6;
    if (ok) begin
      case (cls(w))
        1: begin ep[w] = 1'b1; for (int k = 0; k < CPP; k++) ec[w * CPP + k] = 1'b1; end
        2: ep[w - 8] = 1'b1;
        3: ec[w - 16] = 1'b1;
        default: em[(w - 32) / 2] = 1'b1;
      endcase
      mdl[w] = {8'h00, d[23:0]};
    end
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    check({tag, " strobe pll"}, 32'(pll_upd), 32'(ep));
    check({tag, " strobe chan"}, 32'(chan_upd), 32'(ec));
    check({tag, " strobe mux"}, 32'(mux_upd), 32'(em));
    @(negedge clk);
    check("R9 strobes drop", 32'({pll_upd, chan_upd, mux_upd}), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < NW; w++) mdl[w] = (cls(w) == 2) ? 32'h0001_0000 : 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset strobes", 32'({pll_upd, chan_upd, mux_upd}), 32'd0);
    check_all("R1 reset value");

    // R3 R5 R10 R11 R12: keyed writes with distinct patterns to every writable word
    for (int w = 0; w < NW; w++)
      if (cls(w) != 0 && cls(w) != 6)
        do_write("R5 R10 R11 R12 keyed write", 8'(4 * w),
                 {8'h5A, 24'(w * 24'h03_0507) ^ 24'hA5_C3E1});
    check_all("R3 R5 readback");

    // R2: keys off by one bit, and a zero key
    for (int k = 0; k < 9; k++)
      for (int w = 0; w < NW; w++)
        if (cls(w) != 0 && cls(w) != 6)
          do_write("R2 bad key", 8'(4 * w),
                   {(k == 8) ? 8'h00 : (8'h5A ^ (8'h01 << k)), 24'hFF_FFFF});
    check_all("R2 unchanged");

    // R4: misaligned keyed writes and misaligned reads
    for (int w = 0; w < NW; w++)
      if (cls(w) != 0 && cls(w) != 6)
        for (int o = 1; o < 4; o++) begin
          do_write("R4 misaligned write", 8'(4 * w + o), 32'h5A12_3456);
          rd_check("R4 misaligned read", 8'(4 * w + o), 32'h0);
        end
    check_all("R4 unchanged");

    // R7 R8: keyed writes to lock word and unused words
    for (int w = 0; w < NW; w++)
      if (cls(w) == 0 || cls(w) == 6)
        do_write("R7 R8 non-writable", 8'(4 * w), 32'h5AFF_FFFF);
    check_all("R7 R8 reads");

    // R6: every power-down / analog-reset combination per PLL
    for (int p = 0; p < NP; p++) begin
      for (int c = 0; c < 4; c++) begin
        do_write("R10 lock cm", 8'(4 * p), {8'h5A, 15'd0, c[0], 8'h3C});
        do_write("R10 lock ana", 8'(4 * (8 + p)), {8'h5A, 7'd0, c[1], 16'h1234});
        rd_check("R6 lock word", 8'(4 * (NW - 1)), expect_word(NW - 1));
      end
      do_write("R6 unlock cm", 8'(4 * p), 32'h5A00_0000);
      do_write("R6 unlock ana", 8'(4 * (8 + p)), 32'h5A00_0001);
      rd_check("R6 lock word", 8'(4 * (NW - 1)), expect_word(NW - 1));
    end
    check("R6 all locked", expect_word(NW - 1), 32'h0000_001F);
    check_all("R6 final");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule